// File: doc/BRIEF.md
# Keyed Flash Command Controller

This block is a register-mapped command front end for an embedded flash array. Software writes address, data, key, command and interrupt-enable registers over a simple single-cycle bus and reads back a status register. The block runs two commands: a page erase followed by a read-back check that every word is erased, and a signature pass that computes a CRC-32 over a range of pages and compares it with a stored word. It also launches keyhole writes, where two data words go to flash at the address held in the address register.

Commands are guarded by a 32-bit unlock value that is used up by one accepted command. The keyhole address and data registers lock while a write is being issued. They unlock once the last word has been handed to the flash port, so software can load the next write before the current one finishes. Status flags are sticky and clear when status is read. One interrupt line combines the enabled flags. Toward the flash the block uses a one-cycle request pulse and waits for a done pulse that carries any read data.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, status reads 0, the command register reads 0, `irq` is 0 and `fl_req` is 0.
- R2: Erase (code 1) and signature (code 2) are accepted only if the most recent key-register write (index 3) was 0xF123F456. No command may be running, no keyhole write may be active or pending, and the key must not yet have been used by an earlier nonzero command write. A rejected command makes no flash request and sets the error bit (status bit 4).
- R3: The command register (index 2) keeps a 5-bit field and reads back zero above bit 4. Code 0 has no effect. Codes 3 to 31 are rejected with the error bit.
- R4: Erase sends one erase request for the page that holds address register A (index 4), with flash op 2. It then reads every word of that page in ascending order (op 0). Any word other than 0xFFFFFFFF sets the error bit when the command ends.
- R5: Signature covers the pages from A's page to the page of address register B (index 5). It runs a CRC-32 over words in ascending order: polynomial 0x04C11DB7, MSB first, initial value 0xFFFFFFFF, no final inversion. The last word of the last page is left out of the CRC. The result is readable at index 8, and if it differs from that last word the error bit is set. If B's page is below A's page, the command is rejected.
- R6: Status bit 0 (busy) is 1 from the cycle after an accepted command until the command finishes, and it is never 1 while bit 1 is 1.
- R7: Writing data register 1 (index 7) launches a write: data register 0 (index 6) goes to A's word address, then data register 1 goes to the next word (op 1). Status bit 1 (closed) is set while words are being issued. While it is set, writes to indices 4 to 7 are ignored.
- R8: When the second word request is issued, status bit 3 (almost done) sets and bit 1 clears. A data-1 write made after that point is held and launched once the running write ends.
- R9: Status bit 2 (done) sets when a command or keyhole write finishes and stays set until status (index 0) is read. If a set and a read fall in the same cycle, the set wins. Reading status also clears bits 3 and 4.
- R10: The interrupt-enable register (index 1) keeps 3 bits: bit 0 for done, bit 1 for almost done, bit 2 for error. `irq` is a register equal to the OR of each enabled flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after `bus_rd` |
| bus_rvalid | output | 1 | Read data valid |
| irq | output | 1 | Interrupt |
| fl_req | output | 1 | Flash request pulse |
| fl_op | output | 2 | 0 read, 1 write, 2 page erase |
| fl_addr | output | FL_AW | Flash byte address |
| fl_wdata | output | 32 | Flash write data |
| fl_done | input | 1 | Flash operation finished |
| fl_rdata | input | 32 | Flash read data, valid with `fl_done` |

## Verification
The assertions check on every cycle that busy and closed never overlap and that a flash request lasts one cycle. They also check that a command starts only with the key armed, that the done flag stays set until a status read, that the address register holds while closed, and that `irq` stays low with every enable off. Only the bench scenarios can show the data results. These are the erased page contents, the verify failure from a stuck word, the CRC value and a signature mismatch, the two keyhole words landing at the right addresses, and the early reopen after the almost-done interrupt.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam logic [31:0] UNLOCK_KEY  = 32'hF123F456;
  localparam logic [31:0] CRC_POLY    = 32'h04C11DB7;
  localparam logic [31:0] ERASED_WORD = 32'hFFFFFFFF;

  localparam logic [4:0] CMD_NONE  = 5'd0;
  localparam logic [4:0] CMD_ERASE = 5'd1;
  localparam logic [4:0] CMD_SIGN  = 5'd2;

  localparam logic [1:0] FOP_READ  = 2'd0;
  localparam logic [1:0] FOP_WRITE = 2'd1;
  localparam logic [1:0] FOP_ERASE = 2'd2;

  localparam logic [3:0] RA_STATUS = 4'd0;
  localparam logic [3:0] RA_IE     = 4'd1;
  localparam logic [3:0] RA_CMD    = 4'd2;
  localparam logic [3:0] RA_KEY    = 4'd3;
  localparam logic [3:0] RA_ADDR0  = 4'd4;
  localparam logic [3:0] RA_ADDR1  = 4'd5;
  localparam logic [3:0] RA_DATA0  = 4'd6;
  localparam logic [3:0] RA_DATA1  = 4'd7;
  localparam logic [3:0] RA_SIG    = 4'd8;

  typedef enum logic [1:0] {M_ERASE, M_SIGN, M_WRITE} seq_mode_e;

  // one 32-bit word folded into the running CRC, MSB first
  function automatic logic [31:0] crc32_word(input logic [31:0] c, input logic [31:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 31; i >= 0; i--) begin
      if (r[31] ^ d[i]) r = {r[30:0], 1'b0} ^ CRC_POLY;
      else              r = {r[30:0], 1'b0};
    end
    return r;
  endfunction
endpackage

// File: rtl/flash_cmd_regs.sv
module flash_cmd_regs
  import flash_cmd_pkg::*;
#(
  parameter int FL_AW      = 8,
  parameter int PAGE_BYTES = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [3:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic             bus_rvalid,
  output logic             irq,
  input  logic             seq_idle,
  input  logic             cmd_busy,
  input  logic             wr_closed,
  input  logic             almost_pulse,
  input  logic             done_pulse,
  input  logic             err_pulse,
  input  logic [31:0]      sig_val,
  output logic             start_erase,
  output logic             start_sign,
  output logic             start_write,
  output logic [FL_AW-1:0] addr0_q,
  output logic [FL_AW-1:0] addr1_q,
  output logic [31:0]      data0_q,
  output logic [31:0]      data1_q,
  output logic             key_armed,
  output logic [4:0]       status_q,
  output logic [2:0]       ie_q
);
  localparam int PG_LSB = $clog2(PAGE_BYTES);

  logic [4:0] cmd_q;
  logic       wr_pend, done_f, almost_f, err_f;
  logic       is_cmd, can_run, range_ok, cmd_reject, d1_hit, st_clr;
  logic [4:0] code;

  always_comb begin
    is_cmd      = bus_wr && (bus_addr == RA_CMD);
    code        = bus_wdata[4:0];
    can_run     = seq_idle && !wr_pend;
    range_ok    = addr1_q[FL_AW-1:PG_LSB] >= addr0_q[FL_AW-1:PG_LSB];
    start_erase = is_cmd && (code == CMD_ERASE) && key_armed && can_run;
    start_sign  = is_cmd && (code == CMD_SIGN) && key_armed && can_run && range_ok;
    cmd_reject  = is_cmd && (code != CMD_NONE) && !start_erase && !start_sign;
    d1_hit      = bus_wr && (bus_addr == RA_DATA1) && !wr_closed;
    start_write = seq_idle && (d1_hit || wr_pend);
    st_clr      = bus_rd && (bus_addr == RA_STATUS);
    status_q    = {err_f, almost_f, done_f, wr_closed, cmd_busy};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= '0; ie_q <= '0; key_armed <= 1'b0; wr_pend <= 1'b0;
      addr0_q <= '0; addr1_q <= '0; data0_q <= '0; data1_q <= '0;
    end else begin
      if (is_cmd) cmd_q <= code;
      if (bus_wr && bus_addr == RA_IE) ie_q <= bus_wdata[2:0];
      if (bus_wr && bus_addr == RA_KEY) key_armed <= (bus_wdata == UNLOCK_KEY);
      else if (is_cmd && code != CMD_NONE) key_armed <= 1'b0;
      if (bus_wr && !wr_closed) begin
        if (bus_addr == RA_ADDR0) addr0_q <= bus_wdata[FL_AW-1:0];
        if (bus_addr == RA_ADDR1) addr1_q <= bus_wdata[FL_AW-1:0];
        if (bus_addr == RA_DATA0) data0_q <= bus_wdata;
        if (bus_addr == RA_DATA1) data1_q <= bus_wdata;
      end
      if (start_write)  wr_pend <= 1'b0;
      else if (d1_hit)  wr_pend <= 1'b1;
    end
  end

  // sticky flags: a set in the same cycle as a clearing read wins
  always_ff @(posedge clk) begin
    if (rst) begin
      done_f <= 1'b0; almost_f <= 1'b0; err_f <= 1'b0; irq <= 1'b0;
    end else begin
      done_f   <= (done_f   && !st_clr) || done_pulse;
      almost_f <= (almost_f && !st_clr) || almost_pulse;
      err_f    <= (err_f    && !st_clr) || err_pulse || cmd_reject;
      irq      <= (ie_q[0] && done_f) || (ie_q[1] && almost_f) || (ie_q[2] && err_f);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rvalid <= 1'b0; bus_rdata <= '0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) begin
        case (bus_addr)
          RA_STATUS: bus_rdata <= {27'd0, status_q};
          RA_IE:     bus_rdata <= {29'd0, ie_q};
          RA_CMD:    bus_rdata <= {27'd0, cmd_q};
          RA_ADDR0:  bus_rdata <= 32'(addr0_q);
          RA_ADDR1:  bus_rdata <= 32'(addr1_q);
          RA_DATA0:  bus_rdata <= data0_q;
          RA_DATA1:  bus_rdata <= data1_q;
          RA_SIG:    bus_rdata <= sig_val;
          default:   bus_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int FL_AW      = 8,
  parameter int PAGE_BYTES = 64
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          start_erase,
  input  logic                          start_sign,
  input  logic                          start_write,
  input  logic [FL_AW-3:0]              addr0_w,
  input  logic [FL_AW-$clog2(PAGE_BYTES)-1:0] last_pg,
  input  logic [31:0]                   data0,
  input  logic [31:0]                   data1,
  output logic                          seq_idle,
  output logic                          cmd_busy,
  output logic                          wr_closed,
  output logic                          almost_pulse,
  output logic                          done_pulse,
  output logic                          err_pulse,
  output logic [31:0]                   sig_q,
  output logic                          fl_req,
  output logic [1:0]                    fl_op,
  output logic [FL_AW-1:0]              fl_addr,
  output logic [31:0]                   fl_wdata,
  input  logic                          fl_done,
  input  logic [31:0]                   fl_rdata
);
  localparam int PG_LSB = $clog2(PAGE_BYTES);
  localparam int WL     = PG_LSB - 2;
  localparam int WA     = FL_AW - 2;

  typedef enum logic [2:0] {S_IDLE, S_ERASE, S_ERASE_W, S_READ, S_READ_W,
                            S_WRITE, S_WRITE_W, S_END} st_e;
  st_e         st;
  seq_mode_e   mode;
  logic [WA-1:0] cur, last;
  logic [31:0] crc;
  logic        err_acc, half;

  assign seq_idle = (st == S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; mode <= M_ERASE; cur <= '0; last <= '0; crc <= '0;
      err_acc <= 1'b0; half <= 1'b0; sig_q <= '0;
      cmd_busy <= 1'b0; wr_closed <= 1'b0;
      almost_pulse <= 1'b0; done_pulse <= 1'b0; err_pulse <= 1'b0;
      fl_req <= 1'b0; fl_op <= FOP_READ; fl_addr <= '0; fl_wdata <= '0;
    end else begin
      fl_req <= 1'b0; almost_pulse <= 1'b0; done_pulse <= 1'b0; err_pulse <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start_erase) begin
            mode <= M_ERASE; cmd_busy <= 1'b1; st <= S_ERASE;
            cur  <= {addr0_w[WA-1:WL], {WL{1'b0}}};
            last <= {addr0_w[WA-1:WL], {WL{1'b1}}};
          end else if (start_sign) begin
            mode <= M_SIGN; cmd_busy <= 1'b1; st <= S_READ; crc <= 32'hFFFFFFFF;
            cur  <= {addr0_w[WA-1:WL], {WL{1'b0}}};
            last <= {last_pg, {WL{1'b1}}};
          end else if (start_write) begin
            mode <= M_WRITE; wr_closed <= 1'b1; st <= S_WRITE;
            cur <= addr0_w; half <= 1'b0;
          end
        end
        S_ERASE: begin
          fl_req <= 1'b1; fl_op <= FOP_ERASE; fl_addr <= {cur, 2'b00};
          st <= S_ERASE_W;
        end
        S_ERASE_W: if (fl_done) st <= S_READ;
        S_READ: begin
          fl_req <= 1'b1; fl_op <= FOP_READ; fl_addr <= {cur, 2'b00};
          st <= S_READ_W;
        end
        S_READ_W: if (fl_done) begin
          if (mode == M_ERASE) begin
            if (fl_rdata != ERASED_WORD) err_acc <= 1'b1;
          end else if (cur == last) begin
            sig_q <= crc;
            if (fl_rdata != crc) err_acc <= 1'b1;
          end else begin
            crc <= crc32_word(crc, fl_rdata);
          end
          if (cur == last) st <= S_END;
          else begin cur <= cur + 1'b1; st <= S_READ; end
        end
        S_WRITE: begin
          fl_req <= 1'b1; fl_op <= FOP_WRITE; fl_addr <= {cur, 2'b00};
          fl_wdata <= half ? data1 : data0;
          if (half) begin almost_pulse <= 1'b1; wr_closed <= 1'b0; end
          st <= S_WRITE_W;
        end
        S_WRITE_W: if (fl_done) begin
          if (!half) begin half <= 1'b1; cur <= cur + 1'b1; st <= S_WRITE; end
          else st <= S_END;
        end
        S_END: begin
          done_pulse <= 1'b1; err_pulse <= err_acc; err_acc <= 1'b0;
          cmd_busy <= 1'b0; st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int FL_AW      = 8,
  parameter int PAGE_BYTES = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [3:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic             bus_rvalid,
  output logic             irq,
  output logic             fl_req,
  output logic [1:0]       fl_op,
  output logic [FL_AW-1:0] fl_addr,
  output logic [31:0]      fl_wdata,
  input  logic             fl_done,
  input  logic [31:0]      fl_rdata
);
  localparam int PG_LSB = $clog2(PAGE_BYTES);

  logic             seq_idle, cmd_busy, wr_closed, almost_pulse, done_pulse, err_pulse;
  logic             start_erase, start_sign, start_write, key_armed;
  logic [31:0]      sig_val, data0_q, data1_q;
  logic [FL_AW-1:0] addr0_q, addr1_q;
  logic [4:0]       status_q;
  logic [2:0]       ie_q;

  flash_cmd_regs #(.FL_AW(FL_AW), .PAGE_BYTES(PAGE_BYTES)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .irq(irq),
    .seq_idle(seq_idle), .cmd_busy(cmd_busy), .wr_closed(wr_closed),
    .almost_pulse(almost_pulse), .done_pulse(done_pulse), .err_pulse(err_pulse),
    .sig_val(sig_val), .start_erase(start_erase), .start_sign(start_sign),
    .start_write(start_write), .addr0_q(addr0_q), .addr1_q(addr1_q),
    .data0_q(data0_q), .data1_q(data1_q), .key_armed(key_armed),
    .status_q(status_q), .ie_q(ie_q)
  );

  flash_cmd_seq #(.FL_AW(FL_AW), .PAGE_BYTES(PAGE_BYTES)) u_seq (
    .clk(clk), .rst(rst), .start_erase(start_erase), .start_sign(start_sign),
    .start_write(start_write), .addr0_w(addr0_q[FL_AW-1:2]),
    .last_pg(addr1_q[FL_AW-1:PG_LSB]), .data0(data0_q), .data1(data1_q),
    .seq_idle(seq_idle), .cmd_busy(cmd_busy), .wr_closed(wr_closed),
    .almost_pulse(almost_pulse), .done_pulse(done_pulse), .err_pulse(err_pulse),
    .sig_q(sig_val), .fl_req(fl_req), .fl_op(fl_op), .fl_addr(fl_addr),
    .fl_wdata(fl_wdata), .fl_done(fl_done), .fl_rdata(fl_rdata)
  );
endmodule

// File: rtl/flash_cmd_chk.sv
module flash_cmd_chk
  import flash_cmd_pkg::*;
#(
  parameter int FL_AW = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic [3:0]       bus_addr,
  input logic             fl_req,
  input logic             irq,
  input logic             cmd_busy,
  input logic             wr_closed,
  input logic             key_armed,
  input logic [4:0]       status_q,
  input logic [2:0]       ie_q,
  input logic [FL_AW-1:0] addr0_q
);
  p_busy_closed_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(cmd_busy && wr_closed));

  p_req_single_r4: assert property (@(posedge clk) disable iff (rst)
    fl_req |=> !fl_req);

  p_key_needed_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(cmd_busy) |-> $past(key_armed));

  p_done_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (status_q[2] && !(bus_rd && bus_addr == RA_STATUS)) |=> status_q[2]);

  p_addr_locked_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_closed && bus_wr && bus_addr == RA_ADDR0) |=> $stable(addr0_q));

  p_irq_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (ie_q == 3'd0) |=> !irq);
endmodule

bind flash_cmd_ctrl flash_cmd_chk #(.FL_AW(FL_AW)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .fl_req(fl_req), .irq(irq), .cmd_busy(cmd_busy), .wr_closed(wr_closed),
  .key_armed(key_armed), .status_q(status_q), .ie_q(ie_q), .addr0_q(addr0_q)
);

// File: tb/test_flash_cmd_ctrl.sv
module test_flash_cmd_ctrl;
  localparam int FL_AW = 8;
  localparam int NW    = 64;
  localparam logic [31:0] KEY = 32'hF123F456;

  logic clk = 1'b0, rst = 1'b1;
  logic bus_wr = 0, bus_rd = 0;
  logic [3:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata, fl_wdata, fl_rdata;
  logic bus_rvalid, irq, fl_req, fl_done;
  logic [1:0] fl_op;
  logic [FL_AW-1:0] fl_addr;

  always #10 clk = ~clk;

  flash_cmd_ctrl #(.FL_AW(FL_AW), .PAGE_BYTES(64)) i_flash_cmd_ctrl (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .irq(irq),
    .fl_req(fl_req), .fl_op(fl_op), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
    .fl_done(fl_done), .fl_rdata(fl_rdata)
  );

  // behavioural flash: erase 5, read 2, write 3 cycles
  logic [31:0] mem [NW];
  int cnt = 0, req_cnt = 0, stuck_idx = -1;
  logic [1:0] op_l; logic [5:0] wa_l; logic [31:0] wd_l;
  logic [FL_AW-1:0] last_erase = '1;
  initial fl_done = 1'b0;
  initial fl_rdata = '0;
  always @(posedge clk) begin
    fl_done <= 1'b0;
    if (fl_req) begin
      req_cnt <= req_cnt + 1;
      op_l <= fl_op; wa_l <= fl_addr[7:2]; wd_l <= fl_wdata;
      cnt <= (fl_op == 2'd2) ? 5 : (fl_op == 2'd1) ? 3 : 2;
    end else if (cnt != 0) begin
      if (cnt == 1) begin
        fl_done <= 1'b1;
        if (op_l == 2'd0) fl_rdata <= mem[wa_l];
        else if (op_l == 2'd1) mem[wa_l] <= wd_l;
        else begin
          last_erase <= {wa_l[5:4], 6'd0};
          for (int i = 0; i < 16; i++)
            mem[{wa_l[5:4], 4'(i)}] <= ({26'd0, wa_l[5:4], 4'(i)} == 32'(stuck_idx)) ? 32'h0 : 32'hFFFFFFFF;
        end
      end
      cnt <= cnt - 1;
    end
  end

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t q[$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pop the scoreboard on every read return
  always @(negedge clk) begin
    if (bus_rvalid) begin
      if (q.size() == 0) chk(1'b0, "scoreboard underflow", bus_rdata, 32'h0);
      else begin
        item_t it;
        it = q.pop_front();
        chk(bus_rdata == it.exp, it.tag, bus_rdata, it.exp);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd_exp(input logic [3:0] a, input logic [31:0] e, input string tag);
    item_t it;
    it.exp = e; it.tag = tag; q.push_back(it);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] ref_crc(input int first, input int lastw);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int w = first; w < lastw; w++)
      for (int b = 31; b >= 0; b--)
        c = (c[31] ^ mem[w][b]) ? ({c[30:0], 1'b0} ^ 32'h04C11DB7) : {c[30:0], 1'b0};
    return c;
  endfunction

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] crc_ok;
    bit all_ones;
    for (int i = 0; i < NW; i++) mem[i] = 32'h13579BDF ^ (32'(i) * 32'h01020408);
    idle(4); rst = 0;

    // R1 reset state
    chk(irq == 1'b0, "R1 irq", 32'(irq), 0);
    chk(fl_req == 1'b0, "R1 fl_req", 32'(fl_req), 0);
    rd_exp(4'd0, 32'h0, "R1 status");
    rd_exp(4'd2, 32'h0, "R1 command");

    // R3 code 0 ignored, bad code rejected, upper bits read zero
    wr(4'd2, 32'h0);
    rd_exp(4'd0, 32'h0, "R3 idle code");
    wr(4'd3, KEY); wr(4'd2, 32'h3);
    rd_exp(4'd0, 32'h10, "R3 bad code error");
    wr(4'd2, 32'hFFFFFFE2);
    rd_exp(4'd2, 32'h2, "R3 upper bits zero");
    rd_exp(4'd0, 32'h10, "R2 key used by previous command");

    // R2 wrong key
    wr(4'd3, 32'hF123F457); wr(4'd2, 32'h1);
    rd_exp(4'd0, 32'h10, "R2 wrong key");
    chk(req_cnt == 0, "R2 no flash request", 32'(req_cnt), 0);

    // R5 signature over pages 0..1
    crc_ok = ref_crc(0, 31);
    mem[31] = crc_ok;
    wr(4'd3, KEY); wr(4'd4, 32'h04); wr(4'd5, 32'h7C); wr(4'd2, 32'h2);
    idle(400);
    rd_exp(4'd0, 32'h04, "R5 signature match");
    rd_exp(4'd8, crc_ok, "R5 signature value");
    mem[31] = ~crc_ok;
    wr(4'd3, KEY); wr(4'd2, 32'h2);
    idle(400);
    rd_exp(4'd0, 32'h14, "R5 signature mismatch");
    wr(4'd4, 32'h80); wr(4'd5, 32'h40); wr(4'd3, KEY); wr(4'd2, 32'h2);
    rd_exp(4'd0, 32'h10, "R5 reversed range rejected");

    // R4 and R6: erase page 1, command while busy rejected
    wr(4'd3, KEY); wr(4'd4, 32'h44); wr(4'd2, 32'h1);
    rd_exp(4'd0, 32'h01, "R6 busy");
    wr(4'd3, KEY); wr(4'd2, 32'h1);
    idle(300);
    rd_exp(4'd0, 32'h14, "R6 busy reject plus done");
    all_ones = 1;
    for (int i = 16; i < 32; i++) if (mem[i] != 32'hFFFFFFFF) all_ones = 0;
    chk(all_ones, "R4 page erased", 32'(all_ones), 1);
    chk(last_erase == 8'h40, "R4 erase page address", 32'(last_erase), 32'h40);
    rd_exp(4'd0, 32'h0, "R9 cleared by read");

    // R4 verify failure on a stuck word
    stuck_idx = 37;
    wr(4'd3, KEY); wr(4'd4, 32'h80); wr(4'd2, 32'h1);
    idle(300);
    rd_exp(4'd0, 32'h14, "R4 verify error");
    stuck_idx = -1;

    // R7 keyhole write, lock while closed
    wr(4'd4, 32'h88); wr(4'd6, 32'hA5A50001); wr(4'd7, 32'h5A5A0002);
    wr(4'd4, 32'h30); wr(4'd6, 32'hDEADBEEF);
    rd_exp(4'd0, 32'h02, "R7 closed");
    idle(100);
    rd_exp(4'd4, 32'h88, "R7 address kept");
    chk(mem[34] == 32'hA5A50001, "R7 word 0", mem[34], 32'hA5A50001);
    chk(mem[35] == 32'h5A5A0002, "R7 word 1", mem[35], 32'h5A5A0002);
    rd_exp(4'd0, 32'h0C, "R8 R9 done and almost");
    rd_exp(4'd0, 32'h0, "R8 almost cleared");

    // R10 enables, R8 early reopen on almost-done interrupt
    wr(4'd1, 32'hFF);
    rd_exp(4'd1, 32'h7, "R10 enable width");
    wr(4'd1, 32'h2);
    wr(4'd4, 32'h90); wr(4'd6, 32'h11110000); wr(4'd7, 32'h22220000);
    for (int i = 0; i < 60 && !irq; i++) @(negedge clk);
    chk(irq == 1'b1, "R10 almost interrupt", 32'(irq), 1);
    wr(4'd4, 32'hA0); wr(4'd6, 32'h33330000); wr(4'd7, 32'h44440000);
    idle(100);
    chk(mem[36] == 32'h11110000, "R8 first write", mem[36], 32'h11110000);
    chk(mem[37] == 32'h22220000, "R8 first write hi", mem[37], 32'h22220000);
    chk(mem[40] == 32'h33330000, "R8 reopened write", mem[40], 32'h33330000);
    chk(mem[41] == 32'h44440000, "R8 reopened write hi", mem[41], 32'h44440000);
    rd_exp(4'd0, 32'h0C, "R9 status after writes");
    idle(3);
    chk(irq == 1'b0, "R10 irq cleared", 32'(irq), 0);
    wr(4'd1, 32'h4); wr(4'd2, 32'h1);
    idle(3);
    chk(irq == 1'b1, "R10 error interrupt", 32'(irq), 1);
    rd_exp(4'd0, 32'h10, "R10 error flag");
    idle(3);
    chk(q.size() == 0, "scoreboard drained", 32'(q.size()), 0);
    finish_run();
  end
endmodule